// File: doc/BRIEF.md
# Pixel Color Matrix Transform

This block applies a programmable 3x3 matrix with a per-row offset to a stream of pixels, one pixel per clock, so that a video path can move between color spaces such as RGB and YCbCr. Each of the three 12-bit input components is multiplied by a signed 13-bit weight whose value is read as a fraction of 4096. The three products of a row are summed with that row's offset, and a shared power-of-two gain is applied. The result is rounded to the nearest integer and saturated into the 12-bit output range.

Horizontal sync, vertical sync, data enable and the valid strobe travel alongside the data through the same number of register stages, so timing stays aligned at the output. The weights, offsets and gain select are static inputs. The block captures them internally only on cycles where the incoming data enable is low, so a reprogramming never alters an active line part way through.

Top module: `csc_matrix`

## Requirements
- R1: A pixel presented with `in_valid` high at a rising edge appears on the outputs after exactly 3 rising edges. `out_valid`, `out_hs`, `out_vs` and `out_de` carry the values of `in_valid`, `in_hs`, `in_vs` and `in_de` from the same cycle.
- R2: Row k (k=0 gives `out_r`, 1 gives `out_g`, 2 gives `out_b`) uses weights `cfg_coef[13*(3k+j) +: 13]` for j=0 (`in_r`), j=1 (`in_g`) and j=2 (`in_b`), and offset `cfg_off[13*k +: 13]`. All of these are two's complement values. The output is floor(((w0*R + w1*G + w2*B + off*4096) * 2^s + 2048) / 4096), where s is the gain shift.
- R3: Any row result below 0 is output as 0, and any row result above 4095 is output as 4095.
- R4: `cfg_mode` selects the gain shift s: 0 gives x1, 1 gives x2, 2 gives x4, and 3 behaves like 2 (x4).
- R5: Rounding is to nearest, with exact halves rounded upward.
- R6: The offset is expressed in output LSBs and is added before the gain, so the gain also multiplies the offset.
- R7: The configuration inputs are captured only at edges where `in_de` is low. Changes made while `in_de` is high have no effect on the outputs. A pixel already in the pipeline keeps the weights, offset and gain that were in force when it entered.
- R8: While `rst_n` is low, and directly after reset, all outputs are 0.
- R9: Pixels presented on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_r | input | 12 | R or Cr component |
| in_g | input | 12 | G or Y component |
| in_b | input | 12 | B or Cb component |
| in_hs | input | 1 | Horizontal sync in |
| in_vs | input | 1 | Vertical sync in |
| in_de | input | 1 | Data enable in; low allows configuration capture |
| cfg_coef | input | 117 | Nine 13-bit signed weights, row-major |
| cfg_off | input | 39 | Three 13-bit signed row offsets |
| cfg_mode | input | 2 | Gain select |
| out_valid | output | 1 | Output pixel strobe |
| out_r | output | 12 | Row 0 result |
| out_g | output | 12 | Row 1 result |
| out_b | output | 12 | Row 2 result |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data enable |

## Verification
A configuration capture and a pixel still in flight can share a cycle. This happens when a pixel enters with data enable high and the enable drops on the very next cycle while new values wait on the configuration inputs. The bench provokes this case and requires the pixel's result to match the old weights, offset and gain in every term. A mixed result, such as new gain with old weights, is reported as a failure. A second overlap, saturation and rounding on the same result, is covered by vectors whose rounded sum lands just past either end of the output range.

// File: rtl/csc_matrix.sv
module csc_matrix #(
  parameter int DW   = 12,
  parameter int CW   = 13,
  parameter int FRAC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_r,
  input  logic [DW-1:0]     in_g,
  input  logic [DW-1:0]     in_b,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic              in_de,
  input  logic [9*CW-1:0]   cfg_coef,
  input  logic [3*CW-1:0]   cfg_off,
  input  logic [1:0]        cfg_mode,
  output logic              out_valid,
  output logic [DW-1:0]     out_r,
  output logic [DW-1:0]     out_g,
  output logic [DW-1:0]     out_b,
  output logic              out_hs,
  output logic              out_vs,
  output logic              out_de
);

  localparam int LAT = 3;
  localparam int SW  = DW + CW + 6;
  localparam logic signed [SW-1:0] MAXS = SW'((1 << DW) - 1);
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);

  logic [9*CW-1:0] coef_q;
  logic [3*CW-1:0] off_q;
  logic [1:0]      mode_q, mode1_q;
  logic [1:0]      shift1;
  logic [DW-1:0]   comp [3];
  logic [DW-1:0]   res_q [3];
  logic [3:0]      sb_q [LAT];
  logic [1:0]      warm_q;

  assign comp[0] = in_r;
  assign comp[1] = in_g;
  assign comp[2] = in_b;
  assign shift1  = (mode1_q == 2'd0) ? 2'd0 : (mode1_q == 2'd1) ? 2'd1 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_q <= '0;
      off_q  <= '0;
      mode_q <= '0;
    end else if (!in_de) begin
      coef_q <= cfg_coef;
      off_q  <= cfg_off;
      mode_q <= cfg_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode1_q <= '0;
      warm_q  <= '0;
      for (int s = 0; s < LAT; s++) sb_q[s] <= '0;
    end else begin
      mode1_q <= mode_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      sb_q[0] <= {in_valid, in_hs, in_vs, in_de};
      for (int s = 1; s < LAT; s++) sb_q[s] <= sb_q[s-1];
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_row
    logic signed [SW-1:0] p_q [3];
    logic signed [CW-1:0] o_q;
    logic signed [SW-1:0] sum, scaled, rnd, acc_q;

    assign sum    = p_q[0] + p_q[1] + p_q[2] + ({{(SW-CW){o_q[CW-1]}}, o_q} <<< FRAC);
    assign scaled = sum <<< shift1;
    assign rnd    = (scaled + HALF) >>> FRAC;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int j = 0; j < 3; j++) p_q[j] <= '0;
        o_q   <= '0;
        acc_q <= '0;
        res_q[i] <= '0;
      end else begin
        for (int j = 0; j < 3; j++)
          p_q[j] <= $signed({{(SW-DW){1'b0}}, comp[j]}) *
                    $signed({{(SW-CW){coef_q[CW*(3*i+j)+CW-1]}}, coef_q[CW*(3*i+j) +: CW]});
        o_q   <= off_q[CW*i +: CW];
        acc_q <= rnd;
        if (acc_q < 0)          res_q[i] <= '0;
        else if (acc_q > MAXS)  res_q[i] <= MAXS[DW-1:0];
        else                    res_q[i] <= acc_q[DW-1:0];
      end
    end

    AST_SAT_LOW:  assert property (@(posedge clk) disable iff (!rst_n)
                    (acc_q < 0) |=> (res_q[i] == '0));                       // R3
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                    (acc_q > MAXS) |=> (res_q[i] == MAXS[DW-1:0]));          // R3
  end

  assign out_r = res_q[0];
  assign out_g = res_q[1];
  assign out_b = res_q[2];
  assign {out_valid, out_hs, out_vs, out_de} = sb_q[LAT-1];

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
                   (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1
  AST_DE_LAT:    assert property (@(posedge clk) disable iff (!rst_n)
                   (warm_q == 2'd3) |-> (out_de == $past(in_de, 3)));       // R1
  AST_CFG_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                   (warm_q != 2'd0 && in_de) |=> ($stable(coef_q) && $stable(off_q) && $stable(mode_q))); // R7

endmodule

// File: tb/csc_matrix_bench.sv
module csc_matrix_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
  logic [11:0] in_r = '0, in_g = '0, in_b = '0;
  logic [116:0] cfg_coef = '0;
  logic [38:0]  cfg_off = '0;
  logic [1:0]   cfg_mode = '0;
  logic out_valid, out_hs, out_vs, out_de;
  logic [11:0] out_r, out_g, out_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  csc_matrix u_csc_matrix (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .cfg_coef(cfg_coef), .cfg_off(cfg_off),
    .cfg_mode(cfg_mode), .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de));

  // {r, g, b, exp_r, exp_g, exp_b}; weights: row0 {2048,0,0} off 0, row1 {1024,1024,0} off 10,
  // row2 {0,0,-2048} off 2000, gain x2
  localparam logic [71:0] VEC [8] = '{
    {12'd0,    12'd0,    12'd0,    12'd0,    12'd20,   12'd4000},
    {12'd100,  12'd201,  12'd50,   12'd100,  12'd171,  12'd3950},
    {12'd4095, 12'd4095, 12'd4095, 12'd4095, 12'd4095, 12'd0},
    {12'd1,    12'd2,    12'd3,    12'd1,    12'd22,   12'd3997},
    {12'd1000, 12'd0,    12'd4000, 12'd1000, 12'd520,  12'd0},
    {12'd2048, 12'd3000, 12'd1,    12'd2048, 12'd2544, 12'd3999},
    {12'd4095, 12'd0,    12'd2000, 12'd4095, 12'd2068, 12'd2000},
    {12'd3,    12'd0,    12'd4001, 12'd3,    12'd22,   12'd0}
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic set_w(input int k, input int j, input int w);
    cfg_coef[13*(3*k+j) +: 13] = 13'(w);
  endtask

  task automatic load_cfg(input int w [9], input int o [3], input int m);
    for (int k = 0; k < 9; k++) set_w(k / 3, k % 3, w[k]);
    for (int k = 0; k < 3; k++) cfg_off[13*k +: 13] = 13'(o[k]);
    cfg_mode = 2'(m);
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 0; in_de = 0;
    @(negedge clk);
  endtask

  task automatic one_pixel(input int r, input int g, input int b, input bit de);
    in_r = 12'(r); in_g = 12'(g); in_b = 12'(b); in_valid = 1; in_de = de;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int w [9];
    int o [3];
    repeat (3) @(negedge clk);
    chk("R8 out_valid in reset", out_valid, 0);
    chk("R8 out_r in reset", out_r, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R8 out_b after reset", out_b, 0);
    chk("R8 out_de after reset", out_de, 0);

    // R1 latency and sideband alignment
    w = '{2048,0,0, 0,0,0, 0,0,0}; o = '{0,0,0};
    load_cfg(w, o, 1); settle();
    in_hs = 1; in_vs = 1;
    in_r = 12'd77; in_valid = 1; in_de = 1;
    @(negedge clk); in_valid = 0; in_hs = 0; in_vs = 0; in_de = 0;
    @(negedge clk);
    chk("R1 not yet valid after 2 edges", out_valid, 0);
    @(negedge clk);
    chk("R1 valid after 3 edges", out_valid, 1);
    chk("R1 hs aligned", out_hs, 1);
    chk("R1 vs aligned", out_vs, 1);
    chk("R1 de aligned", out_de, 1);
    chk("R2 exact unity gain", out_r, 77);
    @(negedge clk);
    chk("R1 valid one cycle only", out_valid, 0);

    // R9/R2/R3 table stream
    w = '{2048,0,0, 1024,1024,0, 0,0,-2048}; o = '{0,10,2000};
    load_cfg(w, o, 1); settle();
    for (int k = 0; k < 11; k++) begin
      if (k >= 3) begin
        chk("R9 stream valid", out_valid, 1);
        chk("R2 table out_r", out_r, int'(VEC[k-3][35:24]));
        chk("R3 table out_g", out_g, int'(VEC[k-3][23:12]));
        chk("R3 table out_b", out_b, int'(VEC[k-3][11:0]));
      end
      if (k < 8) begin
        in_r = VEC[k][71:60]; in_g = VEC[k][59:48]; in_b = VEC[k][47:36];
        in_valid = 1; in_de = 1;
      end else begin
        in_valid = 0; in_de = 0;
      end
      @(negedge clk);
    end

    // R4 gain modes, weight 1024 on R, R=1000
    for (int m = 0; m < 4; m++) begin
      w = '{1024,0,0, 0,0,0, 0,0,0}; o = '{0,0,0};
      load_cfg(w, o, m); settle();
      one_pixel(1000, 0, 0, 0);
      chk("R4 gain mode", out_r, (m == 0) ? 250 : (m == 1) ? 500 : 1000);
    end

    // R5 rounding: weight 1, x1
    w = '{1,0,0, 0,0,0, 0,0,0}; o = '{0,0,0};
    load_cfg(w, o, 0); settle();
    one_pixel(2048, 0, 0, 0);
    chk("R5 half rounds up", out_r, 1);
    one_pixel(2047, 0, 0, 0);
    chk("R5 below half rounds down", out_r, 0);

    // R6 offset scaled by gain
    w = '{0,0,0, 2048,0,0, 0,0,0}; o = '{100,-5,-1};
    load_cfg(w, o, 2); settle();
    one_pixel(100, 0, 0, 0);
    chk("R6 offset x4", out_r, 400);
    load_cfg(w, o, 1); settle();
    one_pixel(100, 0, 0, 0);
    chk("R6 negative offset x2", out_g, 90);
    chk("R3 negative clamps", out_b, 0);

    // R7 capture gating and in-flight pixel
    w = '{2048,0,0, 0,0,0, 0,0,0}; o = '{5,0,0};
    load_cfg(w, o, 1); settle();
    in_de = 1;
    @(negedge clk);
    w = '{1024,0,0, 0,0,0, 0,0,0}; o = '{50,0,0};
    load_cfg(w, o, 2);
    @(negedge clk);
    one_pixel(200, 0, 0, 1);
    chk("R7 change during de high ignored", out_r, 210);
    in_de = 1;
    @(negedge clk);
    in_r = 12'd300; in_valid = 1; in_de = 1;
    @(negedge clk);
    in_valid = 0; in_de = 0;
    @(negedge clk);
    in_de = 1;
    @(negedge clk);
    chk("R7 in-flight pixel keeps old config", out_r, 310);
    one_pixel(300, 0, 0, 1);
    chk("R7 new config after de low", out_r, 500);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule